// File: doc/BRIEF.md
# Double-Buffered SPI Master Controller

This block is an 8-bit SPI master with a small register interface for a processor bus. Software sees three registers: control, status and data. A data write does not go straight to the wire. It lands in a one-byte transmit holding buffer. When the shifter is free, the byte moves into the shifter and a transfer begins. While one byte is shifting, software can queue the next one. Each received byte is placed in a receive buffer, which software reads back through the same data address.

The status flags use a two-step protocol. Software first reads the status register while a flag is set, and this arms the clear. A later access to the data or control register then completes it. A data write that was not armed this way is dropped. The shifter runs in SPI mode 0 (clock idles low, MSB first) at the bus clock divided by a parameter. The core also watches the slave-select input for another master on the bus. When it sees one, it aborts the transfer and leaves master mode. It raises interrupt requests for transmit room and for receive or fault events.

Top module: `spi_dual_buf_master`

## Requirements
- R1: After reset, control (address 0) reads 0x00 and status (address 1) reads 0x20. In the status byte, bit 7 is receive-full, bit 5 is transmit-empty and bit 4 is mode-fault. At reset sclk and mosi are low, ssOutN is high and both interrupts are low.
- R2: A data write (address 2) is ignored, leaving transmit-empty at 1 and starting no transfer, unless the most recent status read found transmit-empty at 1.
- R3: An armed data write clears transmit-empty. When the core is idle and in master mode, the byte moves to the shifter and transmit-empty reads 1 again two cycles after the write.
- R4: A byte written while a transfer is running waits in the holding buffer with transmit-empty at 0. It starts automatically after the current transfer ends, so bytes go out in write order.
- R5: A transfer shifts 8 bits MSB first in mode 0 and takes 16×HALF_DIV bus cycles. mosi carries the transmitted byte and the byte sampled on miso lands in the receive buffer.
- R6: Receive-full sets at the end of each transfer. It clears only when a status read that saw it at 1 is followed by a data read. An unarmed data read leaves it set.
- R7: When a transfer ends while receive-full is still set, the new byte is discarded and the receive buffer keeps its old contents.
- R8: A clearing data read in the same cycle that a transfer ends returns the old byte. The new byte is then stored and receive-full stays set.
- R9: Mode-fault sets when ssInN is low, but only while control bits master (bit 0), fault-enable (bit 1) and select-output-enable (bit 2) are 1, 1 and 0.
- R10: A mode fault aborts the running transfer, clears the master bit and drives sclk and mosi low, and the aborted transfer never sets receive-full.
- R11: Mode-fault clears only when a status read that saw it at 1 is followed by a control write.
- R12: irqTx equals transmit-empty AND control bit 3. irqRx equals (receive-full OR mode-fault) AND control bit 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | 2 | Register select: 0 control, 1 status, 2 data |
| busWr | input | 1 | Register write strobe |
| busRd | input | 1 | Register read strobe |
| busWdata | input | 8 | Write data |
| busRdata | output | 8 | Read data, valid in the cycle busRd is high |
| miso | input | 1 | Serial data from the slave |
| ssInN | input | 1 | Slave-select sense, low means another master |
| sclk | output | 1 | SPI clock, idles low |
| mosi | output | 1 | Serial data to the slave |
| ssOutN | output | 1 | Slave-select output, low during a transfer when enabled |
| irqTx | output | 1 | Transmit-room interrupt request |
| irqRx | output | 1 | Receive or fault interrupt request |

## Verification
A data-register read that clears receive-full and the end of a transfer can land in the same bus cycle. The bench provokes this by leaving one byte unread and then arming the receive flag with a status read. It queues a second byte and issues the data read exactly 16×HALF_DIV+1 cycles after that write, which is the cycle the last falling SPI edge completes. The read must return the first reply. Status must still show receive-full, and a second armed read must return the second reply.

// File: rtl/spim_pkg.sv
package spim_pkg;

  localparam int XFER_BITS = 8;

  localparam logic [1:0] ADDR_CTL  = 2'd0;
  localparam logic [1:0] ADDR_STAT = 2'd1;
  localparam logic [1:0] ADDR_DATA = 2'd2;

  // control register image, bit 0 is master
  typedef struct packed {
    logic rxIe;
    logic txIe;
    logic ssOutEn;
    logic faultEn;
    logic master;
  } spim_ctl_t;

  // strobes from control to datapath
  typedef struct packed {
    logic loadTx;
    logic startShift;
    logic captureRx;
    logic abort;
  } spim_strobe_t;

endpackage

// File: rtl/spim_datapath.sv
module spim_datapath
  import spim_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  spim_strobe_t         strb,
  input  logic [XFER_BITS-1:0] wdata,
  input  logic                 miso,
  output logic                 busy,
  output logic                 done,
  output logic                 sclk,
  output logic                 mosi,
  output logic [XFER_BITS-1:0] txBuf,
  output logic [XFER_BITS-1:0] rxBuf
);

  localparam int BW = $clog2(XFER_BITS);
  localparam int CW = (HALF_DIV > 1) ? $clog2(HALF_DIV) : 1;
  localparam logic [BW-1:0] LAST_BIT = BW'(XFER_BITS - 1);

  logic [XFER_BITS-1:0] shiftReg;
  logic [BW-1:0]        bitCnt;
  logic                 sclkQ;
  logic                 sampleBit;
  logic                 halfEnd;

  // half-period timer, omitted when the divider is one
  generate
    if (HALF_DIV == 1) begin : g_nodiv
      assign halfEnd = 1'b1;
    end else begin : g_div
      logic [CW-1:0] divCnt;
      always_ff @(posedge clk) begin
        if (!rstN) divCnt <= '0;
        else if (strb.startShift || strb.abort || !busy || halfEnd) divCnt <= '0;
        else divCnt <= divCnt + 1'b1;
      end
      assign halfEnd = (divCnt == CW'(HALF_DIV - 1));
    end
  endgenerate

  assign done = busy && sclkQ && halfEnd && (bitCnt == LAST_BIT);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy      <= 1'b0;
      sclkQ     <= 1'b0;
      shiftReg  <= '0;
      bitCnt    <= '0;
      sampleBit <= 1'b0;
    end else if (strb.abort) begin
      busy  <= 1'b0;
      sclkQ <= 1'b0;
    end else if (strb.startShift) begin
      shiftReg <= txBuf;
      busy     <= 1'b1;
      sclkQ    <= 1'b0;
      bitCnt   <= '0;
    end else if (busy && halfEnd) begin
      if (!sclkQ) begin
        sclkQ     <= 1'b1;
        sampleBit <= miso;
      end else begin
        sclkQ    <= 1'b0;
        shiftReg <= {shiftReg[XFER_BITS-2:0], sampleBit};
        bitCnt   <= bitCnt + 1'b1;
        if (bitCnt == LAST_BIT) busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txBuf <= '0;
      rxBuf <= '0;
    end else begin
      if (strb.loadTx)    txBuf <= wdata;
      if (strb.captureRx) rxBuf <= {shiftReg[XFER_BITS-2:0], sampleBit};
    end
  end

  assign sclk = sclkQ;
  assign mosi = busy && shiftReg[XFER_BITS-1];

endmodule

// File: rtl/spim_control.sv
module spim_control
  import spim_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic [1:0]   busAddr,
  input  logic         busWr,
  input  logic         busRd,
  input  logic [4:0]   ctlWdata,
  input  logic         ssInN,
  input  logic         busy,
  input  logic         done,
  output spim_strobe_t strb,
  output spim_ctl_t    ctlReg,
  output logic         txEmpty,
  output logic         rxFull,
  output logic         fault,
  output logic         txArm,
  output logic         rxArm,
  output logic         ssOutN,
  output logic         irqTx,
  output logic         irqRx
);

  logic faultArm;
  logic statRd, dataRd, dataWr, ctlWr;
  logic txTake, rxClr, faultClr, faultDet, xferEnd;

  assign statRd = busRd && !busWr && (busAddr == ADDR_STAT);
  assign dataRd = busRd && !busWr && (busAddr == ADDR_DATA);
  assign dataWr = busWr && !busRd && (busAddr == ADDR_DATA);
  assign ctlWr  = busWr && !busRd && (busAddr == ADDR_CTL);

  assign txTake   = dataWr && txArm && txEmpty;
  assign rxClr    = dataRd && rxArm && rxFull;
  assign faultClr = ctlWr && faultArm && fault;
  assign faultDet = ctlReg.master && ctlReg.faultEn && !ctlReg.ssOutEn && !ssInN;
  assign xferEnd  = done && !faultDet;

  always_comb begin
    strb.loadTx     = txTake;
    strb.startShift = ctlReg.master && !busy && !txEmpty && !faultDet;
    strb.captureRx  = xferEnd && (!rxFull || rxClr);
    strb.abort      = faultDet;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlReg   <= '0;
      txEmpty  <= 1'b1;
      rxFull   <= 1'b0;
      fault    <= 1'b0;
      txArm    <= 1'b0;
      rxArm    <= 1'b0;
      faultArm <= 1'b0;
    end else begin
      if (ctlWr) ctlReg <= spim_ctl_t'(ctlWdata);
      if (faultDet) ctlReg.master <= 1'b0;

      if (strb.startShift) txEmpty <= 1'b1;
      else if (txTake)     txEmpty <= 1'b0;

      if (xferEnd)    rxFull <= 1'b1;
      else if (rxClr) rxFull <= 1'b0;

      if (faultDet)      fault <= 1'b1;
      else if (faultClr) fault <= 1'b0;

      if (statRd)      txArm <= txEmpty;
      else if (dataWr) txArm <= 1'b0;

      if (statRd)      rxArm <= rxFull;
      else if (dataRd) rxArm <= 1'b0;

      if (statRd)     faultArm <= fault;
      else if (ctlWr) faultArm <= 1'b0;
    end
  end

  assign ssOutN = !(ctlReg.master && ctlReg.ssOutEn && busy);
  assign irqTx  = txEmpty && ctlReg.txIe;
  assign irqRx  = (rxFull || fault) && ctlReg.rxIe;

endmodule

// File: rtl/spi_dual_buf_master.sv
module spi_dual_buf_master
  import spim_pkg::*;
#(
  parameter int HALF_DIV = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic [1:0] busAddr,
  input  logic       busWr,
  input  logic       busRd,
  input  logic [7:0] busWdata,
  output logic [7:0] busRdata,
  input  logic       miso,
  input  logic       ssInN,
  output logic       sclk,
  output logic       mosi,
  output logic       ssOutN,
  output logic       irqTx,
  output logic       irqRx
);

  spim_strobe_t strb;
  spim_ctl_t    ctlReg;
  logic         txEmpty, rxFull, fault, txArm, rxArm;
  logic         dpBusy, dpDone;
  logic [7:0]   txBuf, rxBuf;

  spim_control u_ctl (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .ctlWdata(busWdata[4:0]), .ssInN(ssInN), .busy(dpBusy), .done(dpDone),
    .strb(strb), .ctlReg(ctlReg), .txEmpty(txEmpty), .rxFull(rxFull),
    .fault(fault), .txArm(txArm), .rxArm(rxArm), .ssOutN(ssOutN),
    .irqTx(irqTx), .irqRx(irqRx)
  );

  spim_datapath #(.HALF_DIV(HALF_DIV)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .wdata(busWdata), .miso(miso),
    .busy(dpBusy), .done(dpDone), .sclk(sclk), .mosi(mosi),
    .txBuf(txBuf), .rxBuf(rxBuf)
  );

  always_comb begin
    busRdata = '0;
    if (busRd) begin
      case (busAddr)
        ADDR_CTL:  busRdata = {3'b000, ctlReg};
        ADDR_STAT: busRdata = {rxFull, 1'b0, txEmpty, fault, 4'b0000};
        ADDR_DATA: busRdata = rxBuf;
        default:   busRdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/spim_checker.sv
module spim_checker (
  input logic       clk,
  input logic       rstN,
  input logic [1:0] busAddr,
  input logic       busWr,
  input logic       busRd,
  input logic       ssInN,
  input logic       busy,
  input logic       done,
  input logic       abort,
  input logic       sclk,
  input logic       master,
  input logic       txEmpty,
  input logic       rxFull,
  input logic       fault,
  input logic       txArm,
  input logic       rxArm,
  input logic [7:0] txBuf,
  input logic [7:0] rxBuf
);

  logic dataWrSeen, dataRdSeen;
  assign dataWrSeen = busWr && !busRd && (busAddr == 2'd2);
  assign dataRdSeen = busRd && !busWr && (busAddr == 2'd2);

  // R2: unarmed data write leaves the holding buffer alone
  a_r2_unarmed_write: assert property (@(posedge clk) disable iff (!rstN)
    (dataWrSeen && !txArm) |=> $stable(txBuf));

  // R4: waiting byte with idle shifter is handed over next cycle
  a_r4_handoff: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && !txEmpty && master && ssInN) |=> (busy && txEmpty));

  // R5: clock idles low outside a transfer
  a_r5_sclk_idle: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> !sclk);

  // R6: completed transfer raises receive-full
  a_r6_rx_full: assert property (@(posedge clk) disable iff (!rstN)
    (done && !abort) |=> rxFull);

  // R7: overrun keeps previous byte
  a_r7_overrun_keep: assert property (@(posedge clk) disable iff (!rstN)
    (done && !abort && rxFull && !(dataRdSeen && rxArm)) |=> ($stable(rxBuf) && rxFull));

  // R10: fault leaves the shifter idle and master mode off
  a_r10_abort_idle: assert property (@(posedge clk) disable iff (!rstN)
    $rose(fault) |-> (!busy && !sclk && !master));

endmodule

bind spi_dual_buf_master spim_checker u_chk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
  .ssInN(ssInN), .busy(dpBusy), .done(dpDone), .abort(strb.abort),
  .sclk(sclk), .master(ctlReg.master), .txEmpty(txEmpty), .rxFull(rxFull),
  .fault(fault), .txArm(txArm), .rxArm(rxArm), .txBuf(txBuf), .rxBuf(rxBuf)
);

// File: tb/tb_spi_dual_buf_master.sv
module tb_spi_dual_buf_master;

  localparam int HALF = 2;
  localparam int XFER_CYC = 16 * HALF;
  localparam logic [1:0] A_CTL = 2'd0, A_STAT = 2'd1, A_DATA = 2'd2;
  // {byte sent, slave reply}
  localparam logic [15:0] VEC [0:4] = '{16'hA53C, 16'h0180, 16'hFF00, 16'h5AC3, 16'h8001};

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [1:0] busAddr = '0;
  logic busWr = 1'b0, busRd = 1'b0;
  logic [7:0] busWdata = '0;
  logic [7:0] busRdata;
  logic miso, ssInN = 1'b1;
  logic sclk, mosi, ssOutN, irqTx, irqRx;

  int nChecks = 0;
  int nErr = 0;

  spi_dual_buf_master #(.HALF_DIV(HALF)) dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWr(busWr), .busRd(busRd),
    .busWdata(busWdata), .busRdata(busRdata), .miso(miso), .ssInN(ssInN),
    .sclk(sclk), .mosi(mosi), .ssOutN(ssOutN), .irqTx(irqTx), .irqRx(irqRx)
  );

  always #5 clk = ~clk;

  // slave model: reply from slvMem, capture mosi on rising sclk
  logic [7:0] slvMem [0:15];
  logic [7:0] slvShift = '0;
  logic [7:0] slvRx = '0;
  int slvBits = 0;
  int slvCnt = 0;
  assign miso = slvShift[7];

  always @(negedge ssOutN or negedge sclk) begin
    if (!ssOutN && slvBits == 0) begin
      slvShift = slvMem[slvCnt % 16];
      slvBits = 8;
      slvCnt++;
    end else if (slvBits != 0) begin
      slvShift = {slvShift[6:0], 1'b0};
      slvBits--;
    end
  end

  always @(posedge sclk) if (!ssOutN) slvRx = {slvRx[6:0], mosi};

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [1:0] a, input logic [7:0] d);
    busAddr = a; busWdata = d; busWr = 1'b1;
    @(posedge clk); @(negedge clk);
    busWr = 1'b0;
  endtask

  task automatic busRead(input logic [1:0] a, output logic [7:0] d);
    busAddr = a; busRd = 1'b1;
    #2 d = busRdata;
    @(posedge clk); @(negedge clk);
    busRd = 1'b0;
  endtask

  task automatic readChk(input logic [1:0] a, input logic [7:0] exp, input string req);
    logic [7:0] d;
    busRead(a, d);
    chk(req, d, exp);
  endtask

  task automatic summary();
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
  endtask

  initial begin
    #2_000_000;
    nChecks++; nErr++;
    $display("FAIL watchdog all: got timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] d;
    int cnt0;
    for (int i = 0; i < 16; i++) slvMem[i] = 8'h00;
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 reset state (status read postponed so no arm exists yet)
    readChk(A_CTL, 8'h00, "R1 control reset");
    chk("R1 sclk reset", {7'b0, sclk}, 8'h00);
    chk("R1 mosi reset", {7'b0, mosi}, 8'h00);
    chk("R1 ssOutN reset", {7'b0, ssOutN}, 8'h01);
    chk("R1 irq reset", {6'b0, irqTx, irqRx}, 8'h00);

    // R2 unarmed write dropped
    busWrite(A_CTL, 8'h05);
    cnt0 = slvCnt;
    busWrite(A_DATA, 8'hA5);
    repeat (40) @(negedge clk);
    readChk(A_STAT, 8'h20, "R1 R2 status after unarmed write");
    chk("R2 no transfer started", 8'(slvCnt - cnt0), 8'h00);

    // table of transfers: R3 R5 R6
    for (int i = 0; i < 5; i++) begin
      slvMem[slvCnt % 16] = VEC[i][7:0];
      cnt0 = slvCnt;
      readChk(A_STAT, 8'h20, "R3 armed status");
      busWrite(A_DATA, VEC[i][15:8]);
      @(negedge clk);
      readChk(A_STAT, 8'h20, "R3 transmit-empty back within two cycles");
      repeat (XFER_CYC + 4) @(negedge clk);
      chk("R5 one frame", 8'(slvCnt - cnt0), 8'h01);
      chk("R5 slave saw byte", slvRx, VEC[i][15:8]);
      readChk(A_DATA, VEC[i][7:0], "R5 received byte");
      readChk(A_STAT, 8'hA0, "R6 unarmed read keeps full");
      readChk(A_DATA, VEC[i][7:0], "R6 armed data read");
      readChk(A_STAT, 8'h20, "R6 full cleared");
    end

    // R4 queued byte, R7 overrun
    cnt0 = slvCnt;
    slvMem[cnt0 % 16] = 8'h9C;
    slvMem[(cnt0 + 1) % 16] = 8'h47;
    readChk(A_STAT, 8'h20, "R4 arm first");
    busWrite(A_DATA, 8'h11);
    @(negedge clk);
    readChk(A_STAT, 8'h20, "R4 room while shifting");
    busWrite(A_DATA, 8'h22);
    readChk(A_STAT, 8'h00, "R4 second byte waiting");
    repeat (2 * XFER_CYC + 12) @(negedge clk);
    chk("R4 two frames", 8'(slvCnt - cnt0), 8'h02);
    chk("R4 last frame is second byte", slvRx, 8'h22);
    readChk(A_STAT, 8'hA0, "R7 full after overrun");
    readChk(A_DATA, 8'h9C, "R7 old byte kept");
    readChk(A_STAT, 8'h20, "R7 cleared");

    // R8 clearing read coincides with transfer end
    cnt0 = slvCnt;
    slvMem[cnt0 % 16] = 8'h6E;
    slvMem[(cnt0 + 1) % 16] = 8'hB1;
    readChk(A_STAT, 8'h20, "R8 arm tx");
    busWrite(A_DATA, 8'h33);
    repeat (XFER_CYC + 4) @(negedge clk);
    readChk(A_STAT, 8'hA0, "R8 arm both");
    busWrite(A_DATA, 8'h44);
    repeat (XFER_CYC) @(negedge clk);
    readChk(A_DATA, 8'h6E, "R8 read at completion returns old");
    readChk(A_STAT, 8'hA0, "R8 new byte keeps full");
    readChk(A_DATA, 8'hB1, "R8 new byte stored");
    readChk(A_STAT, 8'h20, "R8 cleared");

    // R12 interrupts
    busWrite(A_CTL, 8'h1D);
    chk("R12 irqTx", {7'b0, irqTx}, 8'h01);
    chk("R12 irqRx idle", {7'b0, irqRx}, 8'h00);

    // R9 no fault while select output enabled
    busWrite(A_CTL, 8'h07);
    ssInN = 1'b0;
    repeat (3) @(negedge clk);
    readChk(A_CTL, 8'h07, "R9 master kept");
    readChk(A_STAT, 8'h20, "R9 no fault with select output");
    ssInN = 1'b1;

    // R9 R10 fault mid-transfer
    busWrite(A_CTL, 8'h13);
    readChk(A_STAT, 8'h20, "R10 arm tx");
    busWrite(A_DATA, 8'h77);
    repeat (9) @(negedge clk);
    ssInN = 1'b0;
    repeat (2) @(negedge clk);
    chk("R10 sclk idle", {7'b0, sclk}, 8'h00);
    chk("R10 mosi idle", {7'b0, mosi}, 8'h00);
    chk("R12 irqRx on fault", {7'b0, irqRx}, 8'h01);
    readChk(A_CTL, 8'h12, "R10 master cleared");
    ssInN = 1'b1;
    repeat (40) @(negedge clk);

    // R11 clear protocol
    busWrite(A_CTL, 8'h12);
    readChk(A_STAT, 8'h30, "R11 unarmed control write keeps fault");
    busWrite(A_CTL, 8'h02);
    readChk(A_STAT, 8'h20, "R11 fault cleared");
    chk("R10 ssOutN idle", {7'b0, ssOutN}, 8'h01);

    summary();
    $finish;
  end

endmodule